// File: doc/BRIEF.md
# Bridge Driver Power and Fault Supervisor

This block decides, cycle by cycle, whether a dual H-bridge motor driver may drive its windings and accept step commands. It watches the active-low sleep, clear and output-disable pins together with three fault flags from analog detectors: overcurrent, overtemperature and supply undervoltage. From them it produces a global bridge-off command, a home-position clear for the step indexer, a step-accept qualifier, an active-low fault indication and an enable for the internal clock domain.

The two thermal and current faults are handled differently. An overcurrent has to persist for a qualification time before it counts. Once it counts, it is held in a latch that only a clear request or a supply dip can release. An overtemperature acts at once and releases by itself as soon as its flag drops. Leaving sleep, or recovering from reset or undervoltage, starts a settling timer, and steps are refused until it expires. All pins are assumed to be synchronous to `clk`. Each pin is registered once, so every output follows its pins one clock edge later.

Top module: `drive_supervisor`

## Requirements
- R1: While `rst_n` is low and after it, until the pins have been sampled: `bridge_off`=1, `index_clear`=0, `step_ok`=0, `fault_n`=1, `clk_run`=0.
- R2: Each input pin is registered once, so every output reflects the pin values sampled at the most recent rising edge of `clk`.
- R3: With `uv_flag` sampled high: `bridge_off`=1, `index_clear`=1, `clk_run`=0, `step_ok`=0, `fault_n`=1. Undervoltage also erases a latched overcurrent.
- R4: With `wake_n` sampled low (and no undervoltage): `bridge_off`=1, `clk_run`=0, `step_ok`=0, `index_clear`=0, `fault_n`=1. `clear_n`, `hold_off`, `oc_flag` and `ot_flag` are ignored, so a clear pulse during sleep leaves an overcurrent latched.
- R5: After `wake_n` is sampled high following sleep, and likewise after undervoltage or `rst_n` ends, `step_ok` stays 0 for exactly `WAKE_CYCLES` further rising edges and rises on the next one.
- R6: With `hold_off` sampled high: `bridge_off`=1 and `step_ok`=0. This does not release a latched overcurrent.
- R7: With `clear_n` sampled low while awake and powered: `index_clear`=1, `bridge_off`=1 and `step_ok`=0, and the overcurrent latch is cleared at the next edge.
- R8: `oc_flag` sampled high on `OC_QUAL` consecutive edges while awake sets the overcurrent latch one edge after the last of them. The latch then drives `fault_n`=0 and `bridge_off`=1. A run of `OC_QUAL`-1 samples sets nothing.
- R9: A latched overcurrent keeps `fault_n`=0 and `bridge_off`=1 after `oc_flag` drops, until a clear request (R7) or undervoltage (R3).
- R10: With `ot_flag` sampled high while running: `fault_n`=0 and `bridge_off`=1. Both return to normal at the first edge after the flag is sampled low.
- R11: `fault_n` is held at 1 while asleep or settling. A latched overcurrent survives sleep and shows on `fault_n` again once settling ends.
- R12: Faults never gate `step_ok`: with a fault active and all other conditions met, `step_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low reset of the supervisor |
| wake_n | input | 1 | Low requests the low-power sleep state |
| clear_n | input | 1 | Low clears the indexer and the overcurrent latch |
| hold_off | input | 1 | High forces the bridges off and refuses steps |
| oc_flag | input | 1 | Overcurrent detected (raw) |
| ot_flag | input | 1 | Die overtemperature detected |
| uv_flag | input | 1 | Supply below the lockout threshold |
| bridge_off | output | 1 | High disables every bridge switch |
| index_clear | output | 1 | High returns the step indexer to home |
| step_ok | output | 1 | High lets the indexer accept a step edge |
| fault_n | output | 1 | Low reports an overcurrent latch or overtemperature |
| clk_run | output | 1 | High lets the internal clocks run |

## Verification
The assertions take for granted that every pin is already synchronous to `clk` and holds one value per cycle. A value seen through `$past` is therefore the value the sampling register captured. The settling check counts edges from the last raw sleep or undervoltage sample, which assumes `rst_n` itself reloads the settling timer. The bench changes every pin only on the falling edge, so each value is sampled by exactly one rising edge. After every gating pattern it restores the running state and waits out the full settling time, so the patterns never overlap with one another.

// File: rtl/drive_sup_pkg.sv
// Shared types for the bridge driver supervisor.
// Assumes: all pins are synchronous to the supervisor clock.
package drive_sup_pkg;

    // One registered snapshot of the supervisor's input pins.
    typedef struct packed {
        logic uv;        // supply below lockout level
        logic wake_n;    // low = sleep request
        logic clear_n;   // low = indexer / latch clear
        logic hold_off;  // high = outputs disabled
        logic oc;        // overcurrent detector
        logic ot;        // overtemperature detector
    } pin_snap_t;

    // Snapshot value after reset: asleep, cleared, outputs held off.
    localparam pin_snap_t SNAP_RESET = '{
        uv:       1'b0,
        wake_n:   1'b0,
        clear_n:  1'b0,
        hold_off: 1'b1,
        oc:       1'b0,
        ot:       1'b0
    };

endpackage

// File: rtl/drive_sup_sampler.sv
// Registers every input pin once so that all downstream logic sees one
// coherent snapshot per clock. Assumes pins are already synchronous.
module drive_sup_sampler
    import drive_sup_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wake_n,
    input  logic      clear_n,
    input  logic      hold_off,
    input  logic      oc_flag,
    input  logic      ot_flag,
    input  logic      uv_flag,
    output pin_snap_t snap
);

    // Capture all pins on each rising edge; reset to the safe snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= SNAP_RESET;
        end else begin
            snap.uv       <= uv_flag;
            snap.wake_n   <= wake_n;
            snap.clear_n  <= clear_n;
            snap.hold_off <= hold_off;
            snap.oc       <= oc_flag;
            snap.ot       <= ot_flag;
        end
    end

endmodule

// File: rtl/drive_sup_oc_latch.sv
// Overcurrent qualifier and latch. A sampled overcurrent must stay high
// for OC_QUAL consecutive cycles while awake before the latch sets. The
// latch is released only by a clear request while awake or by wipe
// (undervoltage). While asleep the counter and the latch are frozen.
module drive_sup_oc_latch #(
    parameter int OC_QUAL = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic awake,
    input  logic clear_req,
    input  logic oc,
    output logic latched
);

    localparam int CW = (OC_QUAL > 1) ? $clog2(OC_QUAL) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(OC_QUAL - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive overcurrent samples and set the latch at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            run_cnt <= '0;
            latched <= 1'b0;
        end else if (!awake) begin
            run_cnt <= run_cnt;
            latched <= latched;
        end else if (clear_req) begin
            run_cnt <= '0;
            latched <= 1'b0;
        end else if (oc) begin
            if (run_cnt == LIMIT) begin
                latched <= 1'b1;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end else begin
            run_cnt <= '0;
        end
    end

endmodule

// File: rtl/drive_sup_wake_timer.sv
// Settling timer. Reloaded while held (sleep, undervoltage, reset); once
// released it counts WAKE_CYCLES edges, and busy stays high until then.
module drive_sup_wake_timer #(
    parameter int WAKE_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic busy
);

    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

    logic [CW-1:0] remain;

    // Reload while held, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    // Settling is in progress while any count remains.
    always_comb begin
        busy = (remain != '0);
    end

endmodule

// File: rtl/drive_supervisor.sv
// Top of the bridge driver supervisor. Combines the pin snapshot, the
// overcurrent latch and the settling timer into the bridge-off, indexer
// clear, step qualifier, fault and clock-run outputs. All outputs are
// decoded from registers, so each reacts one edge after its pins.
// Assumes pins are synchronous to clk.
module drive_supervisor
    import drive_sup_pkg::*;
#(
    parameter int OC_QUAL     = 1000,
    parameter int WAKE_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_n,
    input  logic clear_n,
    input  logic hold_off,
    input  logic oc_flag,
    input  logic ot_flag,
    input  logic uv_flag,
    output logic bridge_off,
    output logic index_clear,
    output logic step_ok,
    output logic fault_n,
    output logic clk_run
);

    pin_snap_t snap;
    logic      oc_latched;
    logic      settling;
    logic      awake;
    logic      run_ok;
    logic      fault_src;

    drive_sup_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_n   (wake_n),
        .clear_n  (clear_n),
        .hold_off (hold_off),
        .oc_flag  (oc_flag),
        .ot_flag  (ot_flag),
        .uv_flag  (uv_flag),
        .snap     (snap)
    );

    drive_sup_oc_latch #(
        .OC_QUAL (OC_QUAL)
    ) u_oc_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (snap.uv),
        .awake     (snap.wake_n),
        .clear_req (~snap.clear_n),
        .oc        (snap.oc),
        .latched   (oc_latched)
    );

    drive_sup_wake_timer #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_wake_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (snap.uv | ~snap.wake_n),
        .busy  (settling)
    );

    // Derive the operating conditions shared by all outputs.
    always_comb begin
        awake     = snap.wake_n & ~snap.uv;
        run_ok    = awake & ~settling;
        fault_src = oc_latched | snap.ot;
    end

    // Decode the outputs from the operating conditions and the snapshot.
    always_comb begin
        bridge_off  = ~(run_ok & snap.clear_n & ~snap.hold_off & ~fault_src);
        index_clear = snap.uv | (awake & ~snap.clear_n);
        step_ok     = run_ok & snap.clear_n & ~snap.hold_off;
        fault_n     = ~(run_ok & fault_src);
        clk_run     = awake;
    end

endmodule

// File: rtl/drive_sup_checker.sv
// Temporal checks for drive_supervisor, attached with bind. Assumes the
// pins are synchronous to clk, so $past of a pin equals its snapshot.
module drive_sup_checker #(
    parameter int WAKE_CYCLES = 125000
) (
    input logic clk,
    input logic rst_n,
    input logic wake_n,
    input logic clear_n,
    input logic hold_off,
    input logic uv_flag,
    input logic bridge_off,
    input logic index_clear,
    input logic step_ok,
    input logic fault_n,
    input logic clk_run
);

    localparam int SCW = $clog2(WAKE_CYCLES + 2);

    logic           seen;
    logic [SCW-1:0] settle_cnt;

    // Marks cycles whose previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Counts edges since the last raw sleep or undervoltage sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !wake_n || uv_flag) begin
            settle_cnt <= '0;
        end else if (settle_cnt <= SCW'(WAKE_CYCLES)) begin
            settle_cnt <= settle_cnt + SCW'(1);
        end
    end

    // R3
    uv_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(uv_flag)) |->
            (bridge_off && index_clear && !clk_run && !step_ok && fault_n));

    // R4
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!wake_n && !uv_flag)) |->
            (bridge_off && !clk_run && !step_ok && !index_clear && fault_n));

    // R5
    settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok |-> (settle_cnt > SCW'(WAKE_CYCLES)));

    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(hold_off)) |-> (bridge_off && !step_ok));

    // R7
    clear_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!clear_n && wake_n && !uv_flag)) |->
            (index_clear && bridge_off && !step_ok));

    // R11
    fault_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (bridge_off && clk_run));

endmodule

bind drive_supervisor drive_sup_checker #(
    .WAKE_CYCLES (WAKE_CYCLES)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_n      (wake_n),
    .clear_n     (clear_n),
    .hold_off    (hold_off),
    .uv_flag     (uv_flag),
    .bridge_off  (bridge_off),
    .index_clear (index_clear),
    .step_ok     (step_ok),
    .fault_n     (fault_n),
    .clk_run     (clk_run)
);

// File: tb/drive_supervisor_test.sv
`timescale 1ns/1ps
module drive_supervisor_test;

    localparam int QUAL = 4;
    localparam int WAKE = 6;

    logic clk = 1'b0;
    logic rst_n, wake_n, clear_n, hold_off, oc_flag, ot_flag, uv_flag;
    logic bridge_off, index_clear, step_ok, fault_n, clk_run;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    drive_supervisor #(.OC_QUAL(QUAL), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .wake_n(wake_n), .clear_n(clear_n),
        .hold_off(hold_off), .oc_flag(oc_flag), .ot_flag(ot_flag),
        .uv_flag(uv_flag), .bridge_off(bridge_off),
        .index_clear(index_clear), .step_ok(step_ok), .fault_n(fault_n),
        .clk_run(clk_run)
    );

    task automatic check(input string req, input logic [4:0] got,
                         input logic [4:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b (off,clr,step,fault_n,clk)",
                     req, got, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {bridge_off, index_clear, step_ok, fault_n, clk_run};
    endfunction

    task automatic check_bit(input string req, input logic got, input logic exp);
        check(req, {4'b0, got}, {4'b0, exp});
    endtask

    task automatic run_pins();
        wake_n = 1; clear_n = 1; hold_off = 0; oc_flag = 0; ot_flag = 0; uv_flag = 0;
    endtask

    // Pins already released at a falling edge: step_ok low for WAKE edges.
    task automatic expect_settle(input string req);
        for (int i = 0; i < WAKE; i++) begin
            @(negedge clk);
            check_bit(req, step_ok, 1'b0);
        end
        @(negedge clk);
        check_bit(req, step_ok, 1'b1);
    endtask

    task automatic latch_oc();
        oc_flag = 1;
        repeat (QUAL) @(negedge clk);
        oc_flag = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        vectors++;
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        run_pins();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", outs(), 5'b10010);
        rst_n = 1;
        check("R1", outs(), 5'b10010);
        expect_settle("R5 after reset");

        // Sweep gating pins {uv,wake_n,clear_n,hold_off,ot} from running state.
        for (int v = 0; v < 32; v++) begin
            logic u, w, c, h, t, run;
            logic [4:0] exp;
            string req;
            {u, w, c, h, t} = v[4:0];
            uv_flag = u; wake_n = w; clear_n = c; hold_off = h; ot_flag = t;
            @(negedge clk);
            run = !u && w;
            exp = {!(run && c && !h && !t), u || (run && !c),
                   run && c && !h, !(run && t), run};
            if (u)       req = "R3";
            else if (!w) req = "R4";
            else if (!c) req = "R7";
            else if (h)  req = "R6";
            else if (t)  req = "R10";
            else         req = "R2";
            check(req, outs(), exp);
            run_pins();
            repeat (WAKE + 2) @(negedge clk);
        end

        // R5 wake after sleep and after undervoltage
        wake_n = 0;
        repeat (2) @(negedge clk);
        wake_n = 1;
        expect_settle("R5 after sleep");
        uv_flag = 1;
        repeat (2) @(negedge clk);
        uv_flag = 0;
        expect_settle("R5 after undervoltage");

        // R8 a run one sample short does not latch
        oc_flag = 1;
        repeat (QUAL - 1) @(negedge clk);
        oc_flag = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_bit("R8 short run", fault_n, 1'b1);
        end
        // R8 full run latches one edge after the last sample
        oc_flag = 1;
        repeat (QUAL) @(negedge clk);
        check_bit("R8 not early", fault_n, 1'b1);
        oc_flag = 0;
        @(negedge clk);
        check("R8 latched", outs(), 5'b10101);
        // R12 step_ok stays up under a fault (checked in vector above)
        check_bit("R12", step_ok, 1'b1);

        // R9 latch persists; R6 hold_off does not release it
        repeat (4) @(negedge clk);
        check_bit("R9", fault_n, 1'b0);
        hold_off = 1;
        @(negedge clk);
        hold_off = 0;
        repeat (2) @(negedge clk);
        check("R6 latch kept", outs(), 5'b10101);

        // R4 / R11 sleep masks the fault and ignores clear_n
        wake_n = 0;
        @(negedge clk);
        check_bit("R11 asleep", fault_n, 1'b1);
        clear_n = 0;
        @(negedge clk);
        check_bit("R4 clear ignored", index_clear, 1'b0);
        clear_n = 1;
        @(negedge clk);
        wake_n = 1;
        for (int i = 0; i < WAKE; i++) begin
            @(negedge clk);
            check_bit("R11 settling", fault_n, 1'b1);
        end
        @(negedge clk);
        check("R4 latch survived sleep", outs(), 5'b10101);

        // R7 clear releases the latch
        clear_n = 0;
        @(negedge clk);
        check("R7 clearing", outs(), 5'b11001);
        clear_n = 1;
        @(negedge clk);
        check("R7 released", outs(), 5'b00111);

        // R3 undervoltage erases the latch
        latch_oc();
        check_bit("R8 relatch", fault_n, 1'b0);
        uv_flag = 1;
        @(negedge clk);
        check("R3 undervoltage", outs(), 5'b11010);
        uv_flag = 0;
        repeat (WAKE + 1) @(negedge clk);
        check("R3 latch erased", outs(), 5'b00111);

        // R10 overtemperature recovers by itself
        ot_flag = 1;
        @(negedge clk);
        check("R10 hot", outs(), 5'b10101);
        ot_flag = 0;
        @(negedge clk);
        check("R10 cooled", outs(), 5'b00111);

        // R11 overtemperature not reported while asleep
        ot_flag = 1; wake_n = 0;
        @(negedge clk);
        check("R11 hot asleep", outs(), 5'b10010);
        run_pins();
        repeat (WAKE + 2) @(negedge clk);
        check("R2 final", outs(), 5'b00111);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule